// File: doc/BRIEF.md
# Decade Range Tracker with Latched Exponent

This block follows the decade range of an autoranging frequency and period counter. A small exponent counter moves up one code for each range-step pulse that the main counter sends during a measurement. Each measurement reset puts the counter back to its starting code. When the main reading is transferred to the display, the same strobe copies the counter into a storage register. The decimal-point position and the unit select are decoded from that stored code, so the digits, the point and the units all change on the same clock edge.

The stored code is only meaningful in the two autoranging functions: frequency with auto gating and period averaging. In every other function or manual setting the storage is held at zero. The block also drives a flag that allows overflow in those manual settings. A manual reset blanks the decimal point and the units at once and clears the storage on the next edge.

Top module: `exp_range_tracker`

## Requirements
- R1: While rst_ni is low, exp_o is 0. After release, with no stimulus, exp_o stays 0 and dp_o has only bit 0 set.
- R2: A measurement reset (meas_rst_i high at an edge) loads the counter with its high bit set and its other bits clear, which is code 2 for a 2-bit counter. A later transfer makes this value visible on exp_o.
- R3: The counter advances by one for each 0-to-1 transition of step_i seen at the clock. Holding step_i high advances it only once.
- R4: The counter saturates at its all-ones code (3) instead of wrapping.
- R5: In auto mode, exp_o takes the counter value one cycle after a cycle in which xfer_i is high. At all other times exp_o holds its value.
- R6: If a step edge and a transfer occur in the same cycle, storage receives the value from before that step, and the step is still counted.
- R7: Auto mode means auto_i is high and func_i is 0 (frequency) or 1 (period). Outside auto mode, storage is cleared at every edge and exp_o reads 0.
- R8: While man_rst_i is high, dp_o and unit_o are 0 in the same cycle. Storage is cleared at the next edge.
- R9: When man_rst_i is low, dp_o is one-hot, with bit exp_o set.
- R10: When man_rst_i is low, unit_o is 1 for func_i=0 (frequency), 2 for func_i=1 (period), 3 for func_i=2 (time interval) and 0 for func_i=3 (ratio).
- R11: ovf_allow_o is 1 outside auto mode and 0 inside it.
- R12: A measurement reset takes priority over a step edge that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| meas_rst_i | input | 1 | Measurement reset; presets the exponent counter |
| man_rst_i | input | 1 | Manual reset; blanks the decode outputs and clears storage |
| step_i | input | 1 | Range-step signal; each rising edge advances the counter |
| xfer_i | input | 1 | Transfer strobe; copies the counter into storage |
| auto_i | input | 1 | Autoranging selected |
| func_i | input | 2 | Function: 0 frequency, 1 period, 2 interval, 3 ratio |
| exp_o | output | 2 | Stored exponent |
| dp_o | output | 4 | One-hot decimal-point position |
| unit_o | output | 2 | Unit select |
| ovf_allow_o | output | 1 | Overflow allowed (manual setting) |

## Verification
The counter is visible only through storage, and storage loads only on a transfer in auto mode. Every check on the counter therefore needs a sequence: measurement reset, then steps, then a transfer, with the function kept in an auto setting the whole time. The hardest cases to reach are events that land in the same cycle: a step edge together with a transfer, and a step edge together with a measurement reset. Directed sequences line these up on one exact edge. After that, a long run of random input combinations keeps a behavioural model of the counter and storage in step with the design, and the two are compared on every clock.

// File: rtl/exp_range_pkg.sv
package exp_range_pkg;
  typedef enum logic [1:0] {
    FN_FREQ   = 2'd0,
    FN_PERIOD = 2'd1,
    FN_TINT   = 2'd2,
    FN_RATIO  = 2'd3
  } fn_e;

  typedef enum logic [1:0] {
    UN_NONE = 2'd0,
    UN_HZ   = 2'd1,
    UN_SEC  = 2'd2,
    UN_TIME = 2'd3
  } unit_e;
endpackage

// File: rtl/exp_step_cnt.sv
module exp_step_cnt #(
  parameter int EXP_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_rst_i,
  input  logic             step_i,
  output logic [EXP_W-1:0] cnt_o
);
  localparam logic [EXP_W-1:0] PRESET  = {1'b1, {(EXP_W-1){1'b0}}};
  localparam logic [EXP_W-1:0] CNT_MAX = {EXP_W{1'b1}};

  logic             step_q;
  logic [EXP_W-1:0] cnt_q;
  logic             rise;

  assign rise  = step_i & ~step_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= 1'b0;
      cnt_q  <= PRESET;
    end else begin
      step_q <= step_i;
      if (meas_rst_i)                     cnt_q <= PRESET;
      else if (rise && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
    end
  end

  p_preset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_rst_i |=> cnt_q == PRESET);
  p_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !meas_rst_i) |=> cnt_q == CNT_MAX);
  p_hold_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!meas_rst_i && !(step_i && !step_q)) |=> $stable(cnt_q));
endmodule

// File: rtl/exp_store.sv
module exp_store #(
  parameter int EXP_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             auto_i,
  input  logic             man_rst_i,
  input  logic             xfer_i,
  input  logic [EXP_W-1:0] cnt_i,
  output logic [EXP_W-1:0] exp_o
);
  logic [EXP_W-1:0] exp_q;
  assign exp_o = exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   exp_q <= '0;
    else if (!auto_i || man_rst_i) exp_q <= '0;
    else if (xfer_i)               exp_q <= cnt_i;
  end

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_i |=> exp_q == '0);
  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && !man_rst_i && xfer_i) |=> exp_q == $past(cnt_i));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && !man_rst_i && !xfer_i) |=> $stable(exp_q));
  p_man_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_rst_i |=> exp_q == '0);
endmodule

// File: rtl/exp_decode.sv
module exp_decode
  import exp_range_pkg::*;
#(
  parameter int EXP_W = 2,
  parameter int DP_W  = 1 << EXP_W
) (
  input  logic             rst_ni,
  input  logic             man_rst_i,
  input  logic [1:0]       func_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [DP_W-1:0]  dp_o,
  output logic [1:0]       unit_o
);
  unit_e unit;

  always_comb begin
    dp_o = '0;
    unit = UN_NONE;
    if (!man_rst_i) begin
      dp_o[exp_i] = 1'b1;
      case (fn_e'(func_i))
        FN_FREQ:   unit = UN_HZ;
        FN_PERIOD: unit = UN_SEC;
        FN_TINT:   unit = UN_TIME;
        default:   unit = UN_NONE;
      endcase
    end
  end

  assign unit_o = unit;

  always_comb begin
    if (rst_ni && !man_rst_i)
      p_dp_onehot_r9: assert ($countones(dp_o) == 1);
    if (rst_ni && man_rst_i)
      p_blank_r8: assert (dp_o == '0 && unit_o == 2'd0);
  end
endmodule

// File: rtl/exp_range_tracker.sv
module exp_range_tracker
  import exp_range_pkg::*;
#(
  parameter int EXP_W = 2,
  parameter int DP_W  = 1 << EXP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             meas_rst_i,
  input  logic             man_rst_i,
  input  logic             step_i,
  input  logic             xfer_i,
  input  logic             auto_i,
  input  logic [1:0]       func_i,
  output logic [EXP_W-1:0] exp_o,
  output logic [DP_W-1:0]  dp_o,
  output logic [1:0]       unit_o,
  output logic             ovf_allow_o
);
  logic             auto_mode;
  logic [EXP_W-1:0] cnt;

  assign auto_mode   = auto_i && (fn_e'(func_i) == FN_FREQ || fn_e'(func_i) == FN_PERIOD);
  assign ovf_allow_o = ~auto_mode;

  exp_step_cnt #(.EXP_W(EXP_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .meas_rst_i (meas_rst_i),
    .step_i     (step_i),
    .cnt_o      (cnt)
  );

  exp_store #(.EXP_W(EXP_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .auto_i    (auto_mode),
    .man_rst_i (man_rst_i),
    .xfer_i    (xfer_i),
    .cnt_i     (cnt),
    .exp_o     (exp_o)
  );

  exp_decode #(.EXP_W(EXP_W), .DP_W(DP_W)) u_dec (
    .rst_ni    (rst_ni),
    .man_rst_i (man_rst_i),
    .func_i    (func_i),
    .exp_i     (exp_o),
    .dp_o      (dp_o),
    .unit_o    (unit_o)
  );

  p_ovf_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_allow_o == !(auto_i && func_i[1] == 1'b0));
endmodule

// File: tb/tb_exp_range_tracker.sv
`timescale 1ns/1ps
module tb_exp_range_tracker;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       meas_rst_i = 1'b0, man_rst_i = 1'b0, step_i = 1'b0, xfer_i = 1'b0, auto_i = 1'b0;
  logic [1:0] func_i = 2'd0;
  logic [1:0] exp_o;
  logic [3:0] dp_o;
  logic [1:0] unit_o;
  logic       ovf_allow_o;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_cnt = 2, m_store = 0;
  bit m_prev = 0;

  always #2.5 clk_i = ~clk_i;

  exp_range_tracker dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .meas_rst_i(meas_rst_i), .man_rst_i(man_rst_i),
    .step_i(step_i), .xfer_i(xfer_i), .auto_i(auto_i), .func_i(func_i),
    .exp_o(exp_o), .dp_o(dp_o), .unit_o(unit_o), .ovf_allow_o(ovf_allow_o)
  );

  task automatic chk(string tag, string req, string name, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s/%s %s act=%0d exp=%0d", tag, req, name, act, exp_v);
    end
  endtask

  task automatic cyc(string tag, bit mr, bit man, bit st, bit xf, bit au, int fn);
    bit am;
    int e_unit;
    @(negedge clk_i);
    meas_rst_i = mr; man_rst_i = man; step_i = st; xfer_i = xf; auto_i = au; func_i = fn[1:0];
    #1;
    am = au && (fn == 0 || fn == 1);
    e_unit = (fn == 0) ? 1 : (fn == 1) ? 2 : (fn == 2) ? 3 : 0;
    chk(tag, "R5", "exp_o", int'(exp_o), m_store);
    chk(tag, "R9", "dp_o", int'(dp_o), man ? 0 : (1 << m_store));
    chk(tag, "R10", "unit_o", int'(unit_o), man ? 0 : e_unit);
    chk(tag, "R11", "ovf_allow_o", int'(ovf_allow_o), am ? 0 : 1);
    // model next state
    if (!am || man)  m_store = 0;
    else if (xf)     m_store = m_cnt;
    if (mr)                m_cnt = 2;
    else if (st && !m_prev) m_cnt = (m_cnt == 3) ? 3 : m_cnt + 1;
    m_prev = st;
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1", "R1", "exp_o in reset", int'(exp_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    cyc("R1", 0, 0, 0, 0, 0, 0);
    cyc("R1", 0, 0, 0, 0, 1, 0);
    // R2 preset visible after transfer
    cyc("R2", 1, 0, 0, 0, 1, 0);
    cyc("R2", 0, 0, 0, 1, 1, 0);
    cyc("R2", 0, 0, 0, 0, 1, 0);
    // R3 held step counts once
    cyc("R3", 0, 0, 1, 0, 1, 0);
    cyc("R3", 0, 0, 1, 0, 1, 0);
    cyc("R3", 0, 0, 1, 1, 1, 0);
    cyc("R3", 0, 0, 0, 0, 1, 0);
    // R4 saturation
    cyc("R4", 0, 0, 1, 0, 1, 0);
    cyc("R4", 0, 0, 0, 0, 1, 0);
    cyc("R4", 0, 0, 1, 0, 1, 0);
    cyc("R4", 0, 0, 0, 1, 1, 0);
    cyc("R4", 0, 0, 0, 0, 1, 0);
    // R12 meas reset beats step
    cyc("R12", 0, 0, 0, 0, 1, 1);
    cyc("R12", 1, 0, 1, 0, 1, 1);
    cyc("R12", 0, 0, 0, 1, 1, 1);
    cyc("R12", 0, 0, 0, 0, 1, 1);
    // R6 step and transfer in the same cycle
    cyc("R6", 0, 0, 1, 1, 1, 1);
    cyc("R6", 0, 0, 0, 0, 1, 1);
    cyc("R6", 0, 0, 0, 1, 1, 1);
    cyc("R6", 0, 0, 0, 0, 1, 1);
    // R7 non-auto functions clear storage
    cyc("R7", 0, 0, 0, 0, 1, 2);
    cyc("R7", 0, 0, 0, 1, 1, 3);
    cyc("R7", 0, 0, 0, 1, 1, 0);
    cyc("R7", 0, 0, 0, 1, 0, 0);
    cyc("R7", 0, 0, 0, 0, 0, 1);
    // R8 manual reset
    cyc("R8", 1, 0, 0, 0, 1, 0);
    cyc("R8", 0, 0, 0, 1, 1, 0);
    cyc("R8", 0, 1, 0, 0, 1, 0);
    cyc("R8", 0, 1, 0, 1, 1, 1);
    cyc("R8", 0, 0, 0, 0, 1, 1);
    // R10 units in each function
    for (int f = 0; f < 4; f++) cyc("R10", 0, 0, 0, 0, 1, f);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom);
      cyc("RND", (r % 11) == 0, (r[7:4] == 4'd0), r[8], r[9] & r[10], r[11] | r[12], r[14:13]);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule